// File: doc/BRIEF.md
# Alignment Marker Cadence Generator

This block produces the periodic request that tells a PCS transmit path when to put an alignment marker into the stream. Once it is started, the request goes high for a short burst and comes back at a fixed interval. Both the burst length and the interval are counted in cycles where the MII valid input is high. On any cycle where valid is low, the internal count holds, and so does the level of the request. The transmit path therefore sees the request move in step with the data it accompanies.

A three-bit rate code and a one-bit period-select input choose the burst length and the interval from a built-in table. The period-select input picks either a shortened interval, which makes link lock quick in simulation, or the full interval used on a real link. Cadence can be started as soon as the transmit PLL reports lock, which is earlier than the lanes report stable, because the transmit path needs markers at the proper spacing before it leaves reset. After it has started, the cadence runs until the next reset and never slips or drops a slot.

Top module: `amc_cadence_gen`

## Requirements
- R1: When the synchronous reset is high at a clock edge, the generator goes idle with `am_o` low. It stays idle with `am_o` low until a new start is accepted.
- R2: While idle, `am_o` stays low. A start request is accepted only at an edge where `start_i` and `pll_locked_i` are both high. `start_i` alone is ignored.
- R3: `am_o` is high in the cycle after the edge at which the start was accepted.
- R4: The pulse width, counted in valid cycles with `am_o` high, depends on `rate_sel_i`. It is 2 for codes 0 (400G), 1 (200G), 3 (50G two-lane with FEC), 4 (50G), 5 (40G) and 7 (spare, which behaves as code 0). It is 5 for code 2 (100G) and 4 for code 6 (25G with FEC).
- R5: With `sim_period_i` = 1, the number of valid cycles from one rising edge of `am_o` to the next is as follows: 640 for codes 0, 1, 4 and 7; 1280 for codes 2 and 6; 512 for code 3; 128 for code 5.
- R6: With `sim_period_i` = 0, that interval is `HW_PERIOD` (default 2560) for every code except 5, which uses `HW_PERIOD_40G` (default 16384).
- R7: On a cycle where `mii_valid_i` is low, the count does not advance and `am_o` keeps its level. A pulse in progress therefore stays high for as long as valid is low.
- R8: `rate_sel_i` and `sim_period_i` are sampled only at the edge where the start is accepted. Changing them while the cadence runs has no effect on the width or the period.
- R9: Once started, the cadence continues whatever happens on `start_i` and `pll_locked_i` afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to begin cadence |
| pll_locked_i | input | 1 | Transmit PLL lock indication, qualifies start |
| rate_sel_i | input | 3 | Rate code, table in R4 to R6 |
| sim_period_i | input | 1 | 1 selects the shortened interval, 0 the full interval |
| mii_valid_i | input | 1 | MII valid; counting happens only when high |
| am_o | output | 1 | Alignment marker insertion request |

## Verification
Every rate code runs under the shortened interval. Four codes also run under the full interval, including the 40G code, whose full interval differs from the others. In each of these runs valid is gated randomly, which separates counting of valid cycles from counting of raw clock cycles. A directed case holds valid low for many cycles in the middle of a pulse, which shows whether the count freezes or leaks. Other directed cases cover the following:
- start without lock, to confirm it is ignored;
- the one-cycle latency from accepted start to the first pulse;
- a rate change during the run, which must not retune a running cadence;
- reset in mid-pulse.

// File: rtl/amc_pkg.sv
package amc_pkg;

    typedef enum logic [2:0] {
        RATE_400G     = 3'd0,
        RATE_200G     = 3'd1,
        RATE_100G     = 3'd2,
        RATE_50G_FEC2 = 3'd3,
        RATE_50G      = 3'd4,
        RATE_40G      = 3'd5,
        RATE_25G_FEC  = 3'd6,
        RATE_SPARE    = 3'd7
    } amc_rate_e;

    localparam int unsigned AMC_RATE_W = 3;

endpackage

// File: rtl/amc_rate_lut.sv
module amc_rate_lut
    import amc_pkg::*;
#(
    parameter int unsigned CNT_W         = 15,
    parameter int unsigned WID_W         = 3,
    parameter int unsigned HW_PERIOD     = 2560,
    parameter int unsigned HW_PERIOD_40G = 16384
) (
    input  logic [AMC_RATE_W-1:0] rate_i,
    input  logic                  sim_i,
    output logic [WID_W-1:0]      width_o,
    output logic [CNT_W-1:0]      period_o
);

    localparam logic [CNT_W-1:0] P_HW    = CNT_W'(HW_PERIOD);
    localparam logic [CNT_W-1:0] P_HW40  = CNT_W'(HW_PERIOD_40G);
    localparam logic [CNT_W-1:0] P_S640  = CNT_W'(640);
    localparam logic [CNT_W-1:0] P_S1280 = CNT_W'(1280);
    localparam logic [CNT_W-1:0] P_S512  = CNT_W'(512);
    localparam logic [CNT_W-1:0] P_S128  = CNT_W'(128);

    logic [CNT_W-1:0] sim_period;
    logic [CNT_W-1:0] hw_period;

    always_comb begin
        width_o    = WID_W'(2);
        sim_period = P_S640;
        hw_period  = P_HW;
        case (rate_i)
            RATE_100G: begin
                width_o    = WID_W'(5);
                sim_period = P_S1280;
            end
            RATE_50G_FEC2: sim_period = P_S512;
            RATE_40G: begin
                sim_period = P_S128;
                hw_period  = P_HW40;
            end
            RATE_25G_FEC: begin
                width_o    = WID_W'(4);
                sim_period = P_S1280;
            end
            default: ;
        endcase
        period_o = sim_i ? sim_period : hw_period;
    end

endmodule

// File: rtl/amc_phase_cnt.sv
module amc_phase_cnt #(
    parameter int unsigned CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             adv_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] phase_o
);

    logic [CNT_W-1:0] phase_d, phase_q;
    logic             at_end;

    assign at_end = (phase_q == period_i - 1'b1);

    always_comb begin
        phase_d = phase_q;
        if (clr_i) begin
            phase_d = '0;
        end else if (adv_i) begin
            phase_d = at_end ? '0 : phase_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_d;
        end
    end

    assign phase_o = phase_q;

    // R7
    phase_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (!adv_i && !clr_i) |=> $stable(phase_q));

endmodule

// File: rtl/amc_cadence_gen.sv
module amc_cadence_gen
    import amc_pkg::*;
#(
    parameter int unsigned CNT_W         = 15,
    parameter int unsigned WID_W         = 3,
    parameter int unsigned HW_PERIOD     = 2560,
    parameter int unsigned HW_PERIOD_40G = 16384
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic                  pll_locked_i,
    input  logic [AMC_RATE_W-1:0] rate_sel_i,
    input  logic                  sim_period_i,
    input  logic                  mii_valid_i,
    output logic                  am_o
);

    localparam int unsigned PAD_W = CNT_W - WID_W;

    typedef struct packed {
        logic             run;
        logic [WID_W-1:0] width;
        logic [CNT_W-1:0] period;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [WID_W-1:0] lut_width;
    logic [CNT_W-1:0] lut_period;
    logic [CNT_W-1:0] phase;
    logic             accept;
    logic             advance;

    amc_rate_lut #(
        .CNT_W        (CNT_W),
        .WID_W        (WID_W),
        .HW_PERIOD    (HW_PERIOD),
        .HW_PERIOD_40G(HW_PERIOD_40G)
    ) u_lut (
        .rate_i  (rate_sel_i),
        .sim_i   (sim_period_i),
        .width_o (lut_width),
        .period_o(lut_period)
    );

    assign accept  = !ctl_q.run && start_i && pll_locked_i;
    assign advance = ctl_q.run && mii_valid_i;

    always_comb begin
        ctl_d = ctl_q;
        if (accept) begin
            ctl_d.run    = 1'b1;
            ctl_d.width  = lut_width;
            ctl_d.period = lut_period;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    amc_phase_cnt #(
        .CNT_W(CNT_W)
    ) u_phase (
        .clk     (clk),
        .rst     (rst),
        .clr_i   (accept),
        .adv_i   (advance),
        .period_i(ctl_q.period),
        .phase_o (phase)
    );

    assign am_o = ctl_q.run && (phase < {{PAD_W{1'b0}}, ctl_q.width});

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!am_o && !ctl_q.run));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !ctl_q.run |-> !am_o);

    // R3
    first_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl_q.run && start_i && pll_locked_i) |=> am_o);

    // R7
    am_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.run && !mii_valid_i) |=> $stable(am_o));

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_q.run |=> ($stable(ctl_q.period) && $stable(ctl_q.width)));

    // R9
    run_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_q.run |=> ctl_q.run);

    // R5
    phase_bound_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_q.run |-> (phase < ctl_q.period));

endmodule

// File: tb/amc_cadence_gen_tb.sv
module amc_cadence_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    // {rate[2:0], sim, width[3:0], period[15:0]}
    localparam logic [23:0] VEC [NVEC] = '{
        {3'd0, 1'b1, 4'd2, 16'd640},
        {3'd1, 1'b1, 4'd2, 16'd640},
        {3'd2, 1'b1, 4'd5, 16'd1280},
        {3'd3, 1'b1, 4'd2, 16'd512},
        {3'd4, 1'b1, 4'd2, 16'd640},
        {3'd5, 1'b1, 4'd2, 16'd128},
        {3'd6, 1'b1, 4'd4, 16'd1280},
        {3'd7, 1'b1, 4'd2, 16'd640},
        {3'd0, 1'b0, 4'd2, 16'd2560},
        {3'd2, 1'b0, 4'd5, 16'd2560},
        {3'd6, 1'b0, 4'd4, 16'd2560},
        {3'd5, 1'b0, 4'd2, 16'd16384}
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       start_i;
    logic       pll_locked_i;
    logic [2:0] rate_sel_i;
    logic       sim_period_i;
    logic       mii_valid_i;
    logic       am_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    amc_cadence_gen u_dut (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .pll_locked_i(pll_locked_i),
        .rate_sel_i  (rate_sel_i),
        .sim_period_i(sim_period_i),
        .mii_valid_i (mii_valid_i),
        .am_o        (am_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; start_i = 1'b0; pll_locked_i = 1'b0; mii_valid_i = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Start cadence; returns at the negedge where the first pulse is visible.
    task automatic start_run(input logic [2:0] rate, input logic sim);
        rate_sel_i = rate; sim_period_i = sim;
        pll_locked_i = 1'b1; start_i = 1'b1; mii_valid_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Width of first pulse and interval to next rise, in valid cycles.
    task automatic measure(output int w, output int p);
        int  rises = 0;
        int  wc = 0;
        int  pc = 0;
        logic prev = 1'b0;
        logic a;
        p = 0;
        while (rises < 2) begin
            a = am_o;
            if (a && !prev) begin
                rises++;
                if (rises == 2) p = pc;
                pc = 0;
            end
            if (rises < 2) begin
                mii_valid_i = ($urandom_range(7) != 0);
                if (mii_valid_i) begin
                    pc++;
                    if (a && rises == 1) wc++;
                end
                prev = a;
                @(negedge clk);
            end
        end
        mii_valid_i = 1'b0;
        w = wc;
    endtask

    initial begin
        int w;
        int p;
        rst = 1'b1; start_i = 1'b0; pll_locked_i = 1'b0;
        rate_sel_i = 3'd0; sim_period_i = 1'b1; mii_valid_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(am_o == 1'b0, "R1 reset state", am_o, 0);

        // Table of rate vectors: R4 width, R5 shortened period, R6 full period
        for (int i = 0; i < NVEC; i++) begin
            do_reset();
            start_run(VEC[i][23:21], VEC[i][20]);
            measure(w, p);
            check(w == int'(VEC[i][19:16]), "R4 pulse width", w, int'(VEC[i][19:16]));
            check(p == int'(VEC[i][15:0]),
                  VEC[i][20] ? "R5 sim period" : "R6 hw period", p, int'(VEC[i][15:0]));
        end

        // R2: start without lock is ignored
        do_reset();
        rate_sel_i = 3'd5; sim_period_i = 1'b1;
        start_i = 1'b1; pll_locked_i = 1'b0; mii_valid_i = 1'b1;
        begin
            int hi = 0;
            repeat (10) begin
                @(negedge clk);
                if (am_o) hi++;
            end
            check(hi == 0, "R2 start without lock", hi, 0);
        end
        // R3: lock arrives, pulse next cycle
        pll_locked_i = 1'b1; mii_valid_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        check(am_o == 1'b1, "R3 first pulse after accept", am_o, 1);

        // R7: freeze in mid-pulse, 100G width 5
        do_reset();
        start_run(3'd2, 1'b1);
        mii_valid_i = 1'b0;
        repeat (30) @(negedge clk);
        check(am_o == 1'b1, "R7 pulse held while valid low", am_o, 1);
        mii_valid_i = 1'b1;
        repeat (4) @(negedge clk);
        check(am_o == 1'b1, "R7 pulse after 4 valid cycles", am_o, 1);
        @(negedge clk);
        check(am_o == 1'b0, "R7 pulse ends after 5 valid cycles", am_o, 0);
        mii_valid_i = 1'b0;

        // R8 and R9: change config and drop start/lock while running
        do_reset();
        start_run(3'd5, 1'b1);
        rate_sel_i = 3'd2; sim_period_i = 1'b0; pll_locked_i = 1'b0;
        measure(w, p);
        check(w == 2, "R8 width unchanged after rate change", w, 2);
        check(p == 128, "R8 R9 period unchanged, cadence continues", p, 128);

        // R1: reset in mid-pulse
        do_reset();
        start_run(3'd2, 1'b1);
        rst = 1'b1;
        @(negedge clk);
        check(am_o == 1'b0, "R1 reset mid-pulse", am_o, 0);
        rst = 1'b0; mii_valid_i = 1'b1;
        begin
            int hi = 0;
            repeat (5) begin
                @(negedge clk);
                if (am_o) hi++;
            end
            check(hi == 0, "R1 idle after reset", hi, 0);
        end

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule